// File: doc/BRIEF.md
# Cycle-Aligned Checksummed Transmit Frame Buffer

This block holds one outgoing master frame between a host write port and a serial byte transmitter. The host loads the frame as a burst: a start strobe, then one data strobe per byte with an address that advances by itself, then an end strobe. The last byte of the burst is a checksum byte. When the burst closes, the block checks it with an XOR sum. A good frame is armed. A bad frame raises a sticky error flag and leaves nothing armed.

An armed frame is not sent at once. It goes out only when the next cycle-start pulse arrives, one byte per valid/ready handshake, and it is sent exactly once. If a cycle-start pulse lands while a burst is still open, the cycle is not skipped. The block raises a boundary flag and starts sending as soon as that burst closes good. A burst that tries to open while a frame is being sent is refused and flagged, so the frame in flight stays intact. While the channel enable is low, every host strobe is ignored.

Top module: `cyc_txbuf`

## Requirements
- R1: While reset is held and after it is released with idle inputs, tx_valid, tx_busy, sum_err, edge_miss and overrun are all low.
- R2: A good frame starts transmission only in the clock after a cyc_start pulse, and each good burst is transmitted at most once. Later cyc_start pulses send nothing until another good burst closes.
- R3: A burst is good when the XOR of all its bytes, the checksum byte included, equals SEED (default 0x52) and it holds between 2 and DEPTH+1 bytes. The transmitted payload is every burst byte except the last.
- R4: Bytes leave in write order, one per clock where tx_valid and tx_ready are both high. tx_data holds steady while tx_valid waits for tx_ready. tx_busy stays high from the first byte until the last byte has been accepted.
- R5: A burst that fails the check sets sum_err, and the next cyc_start transmits nothing.
- R6: A cyc_start pulse while a burst is open sets edge_miss. If that burst then closes good, transmission starts in the clock after the end strobe.
- R7: When a good burst closes, sum_err and overrun clear, and edge_miss takes the value that shows whether that burst straddled a cycle start.
- R8: A start strobe while tx_busy is high, or in the same clock as a cyc_start that launches a frame, is ignored and sets overrun. The frame being sent is unchanged.
- R9: While chan_en is low, ld_start, ld_byte and ld_end have no effect.
- R10: Opening a new burst discards any armed frame that has not been sent yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; host strobes count only when high |
| ld_start | input | 1 | Burst start strobe |
| ld_byte | input | 1 | Burst data strobe |
| ld_data | input | 8 | Burst data byte |
| ld_end | input | 1 | Burst end strobe |
| cyc_start | input | 1 | Communication cycle start pulse |
| tx_ready | input | 1 | Transmitter accepts the current byte |
| tx_valid | output | 1 | A byte is offered to the transmitter |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_busy | output | 1 | A frame transmission is in progress |
| sum_err | output | 1 | Sticky checksum failure flag |
| edge_miss | output | 1 | Sticky cycle-boundary violation flag |
| overrun | output | 1 | Sticky refused-burst flag |

## Verification
The bench places a cycle-start pulse inside an open burst, and also in the same clock as a burst start. A design that drops the late frame or sends it stale would show a missing or wrong byte stream. It sends bursts of exactly DEPTH+1 bytes, DEPTH+2 bytes, and a single checksum byte, which catches an off-by-one in the length window that accepts an oversize frame or sends an empty one. It also opens a burst during a stalled transmission and loads a replacement burst over an armed frame. A design that lets either write through would corrupt the bytes in flight or send a discarded frame.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef logic [7:0] octet_t;
  localparam octet_t CHK_SEED_DEF = 8'h52;
endpackage

// File: rtl/txb_loader.sv
// Burst intake: byte count, running XOR and the write port of the frame store.
module txb_loader #(
  parameter int              DEPTH = 16,
  parameter txb_pkg::octet_t SEED  = txb_pkg::CHK_SEED_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         take,
  input  txb_pkg::octet_t              din,
  output logic [$clog2(DEPTH+3)-1:0]   cnt_o,
  output logic                         good_o,
  output logic                         wr_en,
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] wr_addr
);
  localparam int CW = $clog2(DEPTH+3);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] CNT_SAT = CW'(DEPTH + 2);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MIN = CW'(2);
  localparam logic [CW-1:0] CNT_BUF = CW'(DEPTH);

  logic [CW-1:0]   cnt_q, cnt_d;
  txb_pkg::octet_t xs_q, xs_d;
  logic            upd;

  always_comb begin
    cnt_d = cnt_q;
    xs_d  = xs_q;
    upd   = clr | take;
    if (clr) begin
      cnt_d = '0;
      xs_d  = '0;
    end else if (take) begin
      xs_d = xs_q ^ din;
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      xs_q  <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      xs_q  <= xs_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign good_o  = (xs_q == SEED) && (cnt_q >= CNT_MIN) && (cnt_q <= CNT_MAX);
  assign wr_en   = take && (cnt_q < CNT_BUF);
  assign wr_addr = cnt_q[AW-1:0];
endmodule

// File: rtl/txb_store.sv
// Frame storage: one register per byte, written by the loader, read by the sender.
module txb_store #(
  parameter int DEPTH = 16
) (
  input  logic                                   clk,
  input  logic                                   wr_en,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] wr_addr,
  input  txb_pkg::octet_t                        wr_data,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rd_addr,
  output txb_pkg::octet_t                        rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  txb_pkg::octet_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic cell_we;
    assign cell_we = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk) begin
      if (cell_we) mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/txb_sender.sv
// Transmit sequencer: walks the stored frame, one byte per handshake.
module txb_sender #(
  parameter int DEPTH = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start,
  input  logic [$clog2(DEPTH+3)-1:0]              len_i,
  input  logic                                    tx_ready,
  output logic                                    busy_o,
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0]  idx_o
);
  localparam int CW = $clog2(DEPTH+3);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          busy_q, busy_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [CW-1:0] len_q, len_d;
  logic          last, step, upd;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    len_d  = len_q;
    last   = (idx_q == (len_q - 1'b1));
    step   = busy_q && tx_ready;
    upd    = start | step;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      len_d  = len_i;
    end else if (step) begin
      if (last) busy_d = 1'b0;
      else      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
    end else if (upd) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q[AW-1:0];
endmodule

// File: rtl/cyc_txbuf.sv
module cyc_txbuf #(
  parameter int              DEPTH = 16,
  parameter txb_pkg::octet_t SEED  = txb_pkg::CHK_SEED_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic       ld_start,
  input  logic       ld_byte,
  input  logic [7:0] ld_data,
  input  logic       ld_end,
  input  logic       cyc_start,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_busy,
  output logic       sum_err,
  output logic       edge_miss,
  output logic       overrun
);
  localparam int CW = $clog2(DEPTH+3);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asserted asynchronously, released through two flops
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic          open_q, open_d;
  logic          armed_q, armed_d;
  logic          late_q, late_d;
  logic          err_q, err_d;
  logic          miss_q, miss_d;
  logic          ovr_q, ovr_d;
  logic [CW-1:0] len_q, len_d;

  logic          acc_start, acc_byte, acc_end;
  logic          launch, late_now, hold_off, open_new;
  logic          fin_good, fin_bad, tx_go;
  logic          busy;
  logic [CW-1:0] cnt;
  logic          good;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_idx;
  logic [CW-1:0] send_len;

  always_comb begin
    acc_start = chan_en & ld_start;
    acc_byte  = chan_en & ~ld_start & ld_byte & open_q;
    acc_end   = chan_en & ~ld_start & ~ld_byte & ld_end & open_q;
    launch    = cyc_start & armed_q & ~open_q & ~busy;
    late_now  = late_q | (cyc_start & open_q);
    hold_off  = acc_start & (busy | launch);
    open_new  = acc_start & ~hold_off;
    fin_good  = acc_end & good;
    fin_bad   = acc_end & ~good;
    tx_go     = launch | (fin_good & late_now);
    send_len  = fin_good ? (cnt - 1'b1) : len_q;

    open_d = open_q;
    if (open_new)     open_d = 1'b1;
    else if (acc_end) open_d = 1'b0;

    late_d = late_q;
    if (acc_end)                  late_d = 1'b0;
    else if (cyc_start & open_q)  late_d = 1'b1;

    armed_d = armed_q;
    if (launch | open_new | fin_bad)  armed_d = 1'b0;
    else if (fin_good & ~late_now)    armed_d = 1'b1;

    err_d = err_q;
    if (fin_good)     err_d = 1'b0;
    else if (fin_bad) err_d = 1'b1;

    miss_d = miss_q;
    if (fin_good)                 miss_d = late_now;
    else if (cyc_start & open_q)  miss_d = 1'b1;

    ovr_d = ovr_q;
    if (fin_good)      ovr_d = 1'b0;
    else if (hold_off) ovr_d = 1'b1;

    len_d = fin_good ? (cnt - 1'b1) : len_q;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      open_q  <= 1'b0;
      armed_q <= 1'b0;
      late_q  <= 1'b0;
      err_q   <= 1'b0;
      miss_q  <= 1'b0;
      ovr_q   <= 1'b0;
      len_q   <= '0;
    end else begin
      open_q  <= open_d;
      armed_q <= armed_d;
      late_q  <= late_d;
      err_q   <= err_d;
      miss_q  <= miss_d;
      ovr_q   <= ovr_d;
      if (fin_good) len_q <= len_d;
    end
  end

  txb_loader #(.DEPTH(DEPTH), .SEED(SEED)) u_load (
    .clk     (clk),
    .rst_n   (rs_n),
    .clr     (open_new),
    .take    (acc_byte),
    .din     (ld_data),
    .cnt_o   (cnt),
    .good_o  (good),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
  );

  txb_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (ld_data),
    .rd_addr (rd_idx),
    .rd_data (tx_data)
  );

  txb_sender #(.DEPTH(DEPTH)) u_send (
    .clk      (clk),
    .rst_n    (rs_n),
    .start    (tx_go),
    .len_i    (send_len),
    .tx_ready (tx_ready),
    .busy_o   (busy),
    .idx_o    (rd_idx)
  );

  assign tx_valid  = busy;
  assign tx_busy   = busy;
  assign sum_err   = err_q;
  assign edge_miss = miss_q;
  assign overrun   = ovr_q;
endmodule

// File: rtl/txb_chk.sv
module txb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chan_en,
  input logic       ld_start,
  input logic       ld_end,
  input logic       cyc_start,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_busy,
  input logic       sum_err,
  input logic       edge_miss,
  input logic       overrun
);
  assert_hold_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_launch_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(cyc_start) || $past(ld_end));

  assert_err_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_err) |-> $past(ld_end && chan_en));

  assert_miss_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_miss) |-> $past(cyc_start));

  assert_ovr_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(ld_start && chan_en));

  assert_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en && !cyc_start |=> $stable(sum_err) && $stable(overrun) && !$rose(tx_busy));
endmodule

bind cyc_txbuf txb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_en   (chan_en),
  .ld_start  (ld_start),
  .ld_end    (ld_end),
  .cyc_start (cyc_start),
  .tx_ready  (tx_ready),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_busy   (tx_busy),
  .sum_err   (sum_err),
  .edge_miss (edge_miss),
  .overrun   (overrun)
);

// File: tb/sim_cyc_txbuf.sv
module sim_cyc_txbuf;
  localparam int         DEPTH = 16;
  localparam logic [7:0] SEED  = 8'h52;

  logic clk, rst_n, chan_en, ld_start, ld_byte, ld_end, cyc_start, tx_ready;
  logic [7:0] ld_data, tx_data;
  logic tx_valid, tx_busy, sum_err, edge_miss, overrun;

  cyc_txbuf #(.DEPTH(DEPTH), .SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ld_start(ld_start),
    .ld_byte(ld_byte), .ld_data(ld_data), .ld_end(ld_end),
    .cyc_start(cyc_start), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_busy(tx_busy), .sum_err(sum_err),
    .edge_miss(edge_miss), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_vec = 0, n_bad = 0, cycles = 0, rx_cnt = 0, rdy_mode = 0;
  string phase = "R1";
  logic [7:0] lfsr = 8'hA5;

  // ---------------- reference model ----------------
  logic [7:0] m_acc[$], m_frame[$], m_send[$];
  bit m_open, m_armed, m_late, m_busy, m_err, m_miss, m_ovr;
  bit busy0, launch, late_now, good;
  logic [7:0] x;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = {}; m_frame = {}; m_send = {};
      m_open = 0; m_armed = 0; m_late = 0; m_busy = 0;
      m_err = 0; m_miss = 0; m_ovr = 0;
    end else begin
      busy0    = m_busy;
      launch   = cyc_start && m_armed && !m_open && !m_busy;
      late_now = m_late || (cyc_start && m_open);
      if (m_busy && tx_ready) begin
        void'(m_send.pop_front());
        if (m_send.size() == 0) m_busy = 0;
      end
      if (cyc_start && m_open) begin m_late = 1; m_miss = 1; end
      if (launch) begin m_send = m_frame; m_busy = 1; m_armed = 0; end
      if (chan_en) begin
        if (ld_start) begin
          if (busy0 || launch) m_ovr = 1;
          else begin m_open = 1; m_acc = {}; m_armed = 0; end
        end else if (ld_byte && m_open) begin
          m_acc.push_back(ld_data);
        end else if (ld_end && m_open) begin
          x = 8'h00;
          foreach (m_acc[i]) x ^= m_acc[i];
          good = (x == SEED) && (m_acc.size() >= 2) && (m_acc.size() <= DEPTH + 1);
          m_open = 0; m_late = 0;
          if (good) begin
            m_frame = m_acc[0:m_acc.size()-2];
            m_err = 0; m_ovr = 0; m_miss = late_now;
            if (late_now) begin m_send = m_frame; m_busy = 1; end
            else m_armed = 1;
          end else begin
            m_err = 1; m_armed = 0;
          end
        end
      end
    end
  end

  always @(posedge clk) if (rst_n && tx_valid && tx_ready) rx_cnt++;

  task automatic cmp(input string what, input logic [7:0] act, input logic [7:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h at %0t", phase, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      n_vec++;
      cmp("tx_valid", {7'b0, tx_valid}, {7'b0, m_busy});
      cmp("tx_busy", {7'b0, tx_busy}, {7'b0, m_busy});
      cmp("sum_err", {7'b0, sum_err}, {7'b0, m_err});
      cmp("edge_miss", {7'b0, edge_miss}, {7'b0, m_miss});
      cmp("overrun", {7'b0, overrun}, {7'b0, m_ovr});
      if (m_busy && m_send.size() > 0) cmp("tx_data", tx_data, m_send[0]);
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = (rdy_mode == 0) ? (lfsr[0] | lfsr[2]) : (rdy_mode == 1);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cyc();
    cyc_start = 1; tick(); cyc_start = 0;
  endtask

  // burst: start, payload bytes, checksum byte, end; cyc pulse with byte cyc_at
  task automatic burst(input logic [7:0] pl[$], input bit corrupt, input int cyc_at = -1);
    logic [7:0] cs = SEED;
    foreach (pl[i]) cs ^= pl[i];
    if (corrupt) cs ^= 8'h01;
    ld_start = 1; tick(); ld_start = 0;
    for (int i = 0; i <= pl.size(); i++) begin
      ld_byte = 1;
      ld_data = (i < pl.size()) ? pl[i] : cs;
      cyc_start = (i == cyc_at);
      tick();
    end
    ld_byte = 0; cyc_start = 0;
    ld_end = 1; tick(); ld_end = 0;
  endtask

  task automatic wait_idle();
    tick();
    while (tx_busy) tick();
    tick();
  endtask

  always @(negedge clk) begin
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    int base;
    rst_n = 0; chan_en = 1; ld_start = 0; ld_byte = 0; ld_end = 0;
    ld_data = 0; cyc_start = 0; tx_ready = 0;
    tick(3);
    // R1: outputs quiet in reset
    chk("R1 reset outputs", {tx_valid, tx_busy, sum_err, edge_miss, overrun}, 0);
    rst_n = 1; tick(4);
    chk("R1 after release", {tx_valid, tx_busy, sum_err, edge_miss, overrun}, 0);

    // R3 / R2: good frame waits for the cycle pulse, then goes once
    phase = "R2"; base = rx_cnt;
    q = '{8'h11, 8'h22, 8'h33, 8'h44};
    burst(q, 0); tick(5);
    chk("R2 no send before cycle", rx_cnt - base, 0);
    pulse_cyc(); wait_idle();
    chk("R3 payload length", rx_cnt - base, 4);
    pulse_cyc(); tick(8);
    chk("R2 sent only once", rx_cnt - base, 4);

    // R4: full-depth frame under random backpressure
    phase = "R4"; base = rx_cnt; q = {};
    for (int i = 0; i < DEPTH; i++) q.push_back(8'(i * 29 + 3));
    burst(q, 0); pulse_cyc(); wait_idle();
    chk("R4 full depth bytes", rx_cnt - base, DEPTH);

    // R5: bad checksum suppresses next cycle
    phase = "R5"; base = rx_cnt;
    q = '{8'hA0, 8'h0B};
    burst(q, 1); pulse_cyc(); tick(8);
    chk("R5 nothing sent", rx_cnt - base, 0);
    chk("R5 sum_err set", sum_err, 1);

    // R7: good burst clears error
    phase = "R7"; base = rx_cnt;
    q = '{8'h5C};
    burst(q, 0);
    chk("R7 sum_err cleared", sum_err, 0);
    pulse_cyc(); wait_idle();
    chk("R7 single byte frame", rx_cnt - base, 1);

    // R6: cycle boundary inside the burst
    phase = "R6"; base = rx_cnt;
    q = '{8'h01, 8'h02, 8'h03};
    burst(q, 0, 1);
    chk("R6 edge_miss set", edge_miss, 1);
    wait_idle();
    chk("R6 late frame sent", rx_cnt - base, 3);
    q = '{8'h77};
    burst(q, 0);
    chk("R7 edge_miss cleared", edge_miss, 0);
    pulse_cyc(); wait_idle();

    // R8: burst during a stalled transmission is refused
    phase = "R8"; base = rx_cnt;
    q = '{8'hC1, 8'hC2, 8'hC3};
    burst(q, 0);
    rdy_mode = 2; pulse_cyc(); tick(2);
    q = '{8'hEE, 8'hEF};
    burst(q, 0);
    chk("R8 overrun set", overrun, 1);
    rdy_mode = 0; wait_idle();
    chk("R8 original frame length", rx_cnt - base, 3);
    // start strobe in the launching clock
    phase = "R8"; base = rx_cnt;
    q = '{8'h90, 8'h91};
    burst(q, 0);
    cyc_start = 1; ld_start = 1; tick(); cyc_start = 0; ld_start = 0;
    wait_idle();
    chk("R8 launch-clock start refused", rx_cnt - base, 2);

    // R10: a new burst discards the armed frame
    phase = "R10"; base = rx_cnt;
    q = '{8'h10, 8'h20};
    burst(q, 0);
    q = '{8'h30};
    burst(q, 1);
    pulse_cyc(); tick(8);
    chk("R10 armed frame dropped", rx_cnt - base, 0);

    // R3: oversize and checksum-only bursts are bad
    phase = "R3"; base = rx_cnt; q = {};
    for (int i = 0; i < DEPTH + 1; i++) q.push_back(8'(i + 7));
    burst(q, 0); pulse_cyc(); tick(6);
    chk("R3 oversize rejected", rx_cnt - base, 0);
    chk("R3 oversize sum_err", sum_err, 1);
    q = {};
    burst(q, 0); pulse_cyc(); tick(6);
    chk("R3 checksum-only rejected", rx_cnt - base, 0);

    // R9: strobes ignored while channel disabled
    phase = "R9"; base = rx_cnt;
    chan_en = 0;
    q = '{8'h44, 8'h55};
    burst(q, 0);
    chan_en = 1;
    chk("R9 sum_err unchanged", sum_err, 1);
    pulse_cyc(); tick(6);
    chk("R9 nothing armed", rx_cnt - base, 0);

    tick(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule